// File: doc/BRIEF.md
# Quasi-Bidirectional Port Control

This block holds the per-pin control state for a small parallel port in which every pin serves as an input or an output without any direction setting. Each pin has an output latch bit. A latch bit of 0 turns on a strong pull-down. A latch bit of 1 leaves only a weak pull-up on the pin, so an external device can still drive the pin low. In that state the pin works as an input.

When a write stores a 1 into a bit, a strong pull-up for that pin turns on for a short time, so the rising edge is fast on a heavily loaded line. This boost ends on the next falling edge of the serial clock, which arrives as a one-cycle event strobe. A read strobe captures the resolved pin levels into an input register. The pad drivers are not part of this block. Its three enable vectors go to them, and the pin level comes back on `pin_in`.

Top module: `qb_port_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every latch bit is 1. So `pull_dn_en` is all 0, `weak_up_en` is all 1, `boost_up_en` is all 0, and `rd_data` is all 1.
- R2: In every cycle, bit i of `pull_dn_en` is the inverse of latch bit i, and bit i of `weak_up_en` equals latch bit i. A write (`wr_stb` high) loads `wr_data` into the latch, and the outputs show it from the next cycle.
- R3: A write that stores 1 in bit i sets bit i of `boost_up_en` from the next cycle. This happens even if the latch bit was already 1.
- R4: A `scl_fall` pulse without a write in the same cycle clears every `boost_up_en` bit from the next cycle.
- R5: A bit written as 0 never starts a boost. Writing 0 to a bit that is boosting clears its boost from the next cycle.
- R6: `pull_dn_en` and `boost_up_en` are never both 1 on the same bit.
- R7: `rd_strobe` loads `pin_in` into `rd_data`, visible in the next cycle. Without it, `rd_data` holds its value.
- R8: When `wr_stb` and `scl_fall` are both high in one cycle, the write wins. From the next cycle `boost_up_en` equals `wr_data`.
- R9: A pin written 1 reads back the external level. A pin written 0 reads 0 whatever the external level is.
- R10: `scl_fall` and `rd_strobe` never change the latch. `pull_dn_en` and `weak_up_en` change only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, acts as power-on reset |
| wr_stb | input | 1 | One-cycle strobe that loads `wr_data` into the latch |
| wr_data | input | WIDTH | Byte to drive on the port |
| scl_fall | input | 1 | One-cycle event marking a falling serial clock edge |
| rd_strobe | input | 1 | One-cycle strobe that samples the pins |
| pin_in | input | WIDTH | Resolved pin levels from the pads |
| pull_dn_en | output | WIDTH | Strong pull-down enable per pin |
| weak_up_en | output | WIDTH | Weak pull-up enable per pin |
| boost_up_en | output | WIDTH | Momentary strong pull-up enable per pin |
| rd_data | output | WIDTH | Captured input register |

## Verification
Three kinds of write are tried, and each separates a different fault. Bytes with mixed ones and zeros separate the pull-down path from the boost path. Rewriting bits that are already 1 shows whether a boost starts on each written 1 or only on a 0-to-1 change. Writes that fall in the same cycle as a clock-fall event show whether the write takes priority. Reads are taken while an external device pulls some of the pins written high. This separates pins that act as inputs from pins held low by their own latch. A long random mix of all strobes is compared cycle by cycle against a behavioural model.

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             scl_fall,
  input  logic             rd_strobe,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] weak_up_en,
  output logic [WIDTH-1:0] boost_up_en,
  output logic [WIDTH-1:0] rd_data
);

  localparam logic [WIDTH-1:0] ALL_ONE = '1;

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] boost_q;
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= ALL_ONE;
    end else if (wr_stb) begin
      latch_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost_q <= '0;
    end else if (wr_stb) begin
      boost_q <= wr_data;
    end else if (scl_fall) begin
      boost_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= ALL_ONE;
    end else if (rd_strobe) begin
      rd_q <= pin_in;
    end
  end

  assign pull_dn_en  = ~latch_q;
  assign weak_up_en  = latch_q;
  assign boost_up_en = boost_q & latch_q;
  assign rd_data     = rd_q;

endmodule

// File: rtl/qb_port_ctrl_chk.sv
module qb_port_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic [WIDTH-1:0] wr_data,
  input logic             scl_fall,
  input logic             rd_strobe,
  input logic [WIDTH-1:0] pull_dn_en,
  input logic [WIDTH-1:0] boost_up_en,
  input logic [WIDTH-1:0] rd_data
);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_dn_en & boost_up_en) == '0);

  assert_boost_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (boost_up_en & $past(wr_data)) == $past(wr_data));

  assert_boost_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !wr_stb) |=> boost_up_en == '0);

  assert_no_zero_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (boost_up_en & ~$past(wr_data)) == '0);

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pull_dn_en));

endmodule

bind qb_port_ctrl qb_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .scl_fall(scl_fall), .rd_strobe(rd_strobe), .pull_dn_en(pull_dn_en),
  .boost_up_en(boost_up_en), .rd_data(rd_data)
);

// File: tb/qb_port_ctrl_bench.sv
`timescale 1ns/1ps
module qb_port_ctrl_bench;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_stb = 0, scl_fall = 0, rd_strobe = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] ext_low = '0;
  logic [W-1:0] pin_in;
  logic [W-1:0] pull_dn_en, weak_up_en, boost_up_en, rd_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bit [W-1:0] m_latch = '1;
  bit [W-1:0] m_boost = '0;
  bit [W-1:0] m_rd = '1;

  always #2 clk = ~clk;

  assign pin_in = ~pull_dn_en & ~ext_low;

  qb_port_ctrl #(.WIDTH(W)) u_qb_port_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .scl_fall(scl_fall), .rd_strobe(rd_strobe), .pin_in(pin_in),
    .pull_dn_en(pull_dn_en), .weak_up_en(weak_up_en),
    .boost_up_en(boost_up_en), .rd_data(rd_data)
  );

  // behavioural reference: per pin, in bench terms
  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = '1; m_boost = '0; m_rd = '1;
    end else begin
      for (int i = 0; i < W; i++) begin
        bit lvl;
        lvl = m_latch[i] && !ext_low[i];
        if (rd_strobe) m_rd[i] = lvl;
        if (wr_stb) begin
          m_latch[i] = wr_data[i];
          m_boost[i] = wr_data[i];
        end else if (scl_fall) begin
          m_boost[i] = 1'b0;
        end
      end
    end
  end

  task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("pull_dn_en", pull_dn_en, ~m_latch);
    cmp("weak_up_en", weak_up_en, m_latch);
    cmp("boost_up_en", boost_up_en, m_boost);
    cmp("rd_data", rd_data, m_rd);
    checks++;
    if ((pull_dn_en & boost_up_en) != '0) begin
      errors++;
      $display("FAIL R6 overlap: actual %h expected 00", pull_dn_en & boost_up_en);
    end
  end

  task automatic step(bit w, logic [W-1:0] d, bit s, bit r);
    wr_stb = w; wr_data = d; scl_fall = s; rd_strobe = r;
    @(negedge clk);
    wr_stb = 0; scl_fall = 0; rd_strobe = 0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R2";
    step(1, 8'hA5, 0, 0);
    @(negedge clk);
    cur_req = "R3";
    step(1, 8'hFF, 0, 0);
    @(negedge clk);
    cur_req = "R4";
    step(0, 8'h00, 1, 0);
    @(negedge clk);
    cur_req = "R10";
    step(0, 8'h00, 1, 1);
    step(0, 8'h00, 0, 1);
    cur_req = "R5";
    step(1, 8'h3C, 0, 0);
    step(1, 8'h0C, 0, 0);
    @(negedge clk);
    cur_req = "R8";
    step(1, 8'hC3, 1, 0);
    @(negedge clk);
    cur_req = "R9";
    ext_low = 8'h0F;
    step(0, 8'h00, 0, 1);
    @(negedge clk);
    checks++;
    if (rd_data !== 8'hC0) begin
      errors++;
      $display("FAIL R9 readback: actual %h expected c0", rd_data);
    end
    cur_req = "R7";
    ext_low = 8'hF0;
    @(negedge clk);
    step(0, 8'h00, 0, 1);
    cur_req = "R2/R3/R4/R5/R7/R8/R10 random";
    for (int n = 0; n < 400; n++) begin
      ext_low = W'($urandom);
      step($urandom_range(0, 3) == 0, W'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule